// File: doc/BRIEF.md
# Mailbox Receive Acceptance Filter

This block picks the mailbox that takes a received CAN frame. It is given one frame per strobe: the 29-bit identifier, a flag for the extended format and a flag for a remote request. It compares that frame against the stored settings of 32 mailboxes in parallel. Each mailbox has an identifier, a format bit, a direction, an enable and a mask-select bit. A single cycle later it reports the winning mailbox index with a valid pulse. In the same edge it sets that mailbox's receive-pending flag, or its message-lost flag when the pending flag was still set.

Mailboxes 0 to 30 form the main search. The lowest-numbered match wins, and each of these mailboxes either requires an exact match or applies a shared global mask. Mailbox 31 is a receive-only catch-all. It is tried only when none of the main mailboxes match, and it always applies its own local mask. Each mask also carries a bit that can exclude the frame format from the comparison. Software clears the pending and lost flags through per-mailbox clear vectors and loads both masks through a small write port.

Top module: `rx_accept_filter`

## Requirements
- R1: A mailbox whose format bit is 0 (standard) compares only identifier bits 28 to 18; bits 17 to 0 of the frame are ignored.
- R2: A mailbox whose format bit is 1 (extended) compares all 29 identifier bits.
- R3: With its mask-select bit at 1, a mailbox 0 to 30 treats every identifier bit set in the global mask as don't-care; with the select bit at 0 it requires exact equality.
- R4: When several of mailboxes 0 to 30 match, the lowest index wins.
- R5: Mailbox 31 is chosen only when no mailbox 0 to 30 matches. It always applies the local mask, whatever its own mask-select and direction bits say.
- R6: The format-mask bit (mask_wr_fmt) set to 0 requires the frame format to equal the mailbox format bit; set to 1 the format is not checked. Mailboxes that do not use a mask always check the format.
- R7: A mailbox whose enable bit is 0 never matches.
- R8: A data frame (frame_rtr=0) only matches mailboxes whose direction bit is 1 (receive). A remote frame ignores the direction bit.
- R9: hit_valid is a one-cycle pulse in the cycle after frame_valid, with hit_idx holding the 5-bit winner. With no match, hit_valid stays 0 and no flag is set.
- R10: Storing a frame in mailbox n sets rx_pend[n].
- R11: Storing a frame in mailbox n while rx_pend[n] is already 1 sets rx_lost[n].
- R12: pend_clr[n] and lost_clr[n] clear their flags. If a store to mailbox n and pend_clr[n] fall in the same cycle, rx_pend[n] ends at 1 and rx_lost[n] is not set. If a lost event and lost_clr[n] coincide, rx_lost[n] ends at 1.
- R13: gmask_we and lmask_we load mask_wr_id/mask_wr_fmt at the clock edge. A frame in the same cycle still uses the previous mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | Strobe: a received frame is presented |
| frame_id | input | 29 | Frame identifier, bits 28:18 hold the standard field |
| frame_ext | input | 1 | Frame is in extended format |
| frame_rtr | input | 1 | Frame is a remote request |
| mb_id | input | 928 | Mailbox identifiers, mailbox n at bits n*29 +: 29 |
| mb_ext | input | 32 | Mailbox format bits |
| mb_rx | input | 32 | Mailbox direction, 1 = receive |
| mb_en | input | 32 | Mailbox enables |
| mb_use_mask | input | 32 | Mailbox uses the global mask (mailboxes 0 to 30) |
| gmask_we | input | 1 | Load the global mask |
| lmask_we | input | 1 | Load the local mask |
| mask_wr_id | input | 29 | Mask identifier bits, 1 = don't-care |
| mask_wr_fmt | input | 1 | Mask format bit, 1 = format not checked |
| pend_clr | input | 32 | Clear receive-pending flags |
| lost_clr | input | 32 | Clear message-lost flags |
| hit_valid | output | 1 | A mailbox accepted the last frame |
| hit_idx | output | 5 | Index of the accepting mailbox |
| rx_pend | output | 32 | Receive-pending flags |
| rx_lost | output | 32 | Message-lost flags |

## Verification
The two functions that can share a cycle are a frame store into a mailbox and a software clear of that same mailbox's flags. A mask load racing a frame is a related case. The bench provokes each by holding a clear vector or a mask write in exactly the cycle where frame_valid is high. It judges the outcome at the ports: the clear must lose to the store, a clear of the pending flag must stop a false lost event, and the frame must see the old mask while the next frame sees the new one.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ID_W  = 29;
    localparam int STD_W = 11;

    typedef struct packed {
        logic [ID_W-1:0] id;   // 1 = identifier bit is don't-care
        logic            fmt;  // 1 = frame format not checked
    } acc_mask_t;
endpackage

// File: rtl/rxf_mask_bank.sv
module rxf_mask_bank
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      g_we,
    input  logic      l_we,
    input  acc_mask_t wr_mask,
    output acc_mask_t g_mask,
    output acc_mask_t l_mask
);
    typedef struct packed {
        acc_mask_t g;
        acc_mask_t l;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (g_we) bank_d.g = wr_mask;
        if (l_we) bank_d.l = wr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign g_mask = bank_q.g;
    assign l_mask = bank_q.l;

    assert_gmask_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !g_we |=> $stable(g_mask));
    assert_lmask_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !l_we |=> $stable(l_mask));
endmodule

// File: rtl/rxf_match_cell.sv
module rxf_match_cell
    import rxf_pkg::*;
#(
    parameter bit FALLBACK = 1'b0
)(
    input  logic [ID_W-1:0] frame_id,
    input  logic            frame_ext,
    input  logic            frame_rtr,
    input  logic [ID_W-1:0] cell_id,
    input  logic            cell_ext,
    input  logic            cell_rx,
    input  logic            cell_en,
    input  logic            cell_use_mask,
    input  acc_mask_t       mask,
    output logic            hit
);
    localparam int EXT_ONLY = ID_W - STD_W;

    logic            apply_mask;
    logic            dir_ok;
    logic [ID_W-1:0] care;
    logic [ID_W-1:0] diff;
    logic            fmt_ok;

    // Mailbox variant chosen at elaboration time
    generate
        if (FALLBACK) begin : g_fallback
            assign apply_mask = 1'b1;
            assign dir_ok     = 1'b1;
        end else begin : g_main
            assign apply_mask = cell_use_mask;
            assign dir_ok     = frame_rtr | cell_rx;
        end
    endgenerate

    always_comb begin
        care = {{STD_W{1'b1}}, {EXT_ONLY{cell_ext}}};
        if (apply_mask) care = care & ~mask.id;
        diff   = (frame_id ^ cell_id) & care;
        fmt_ok = (apply_mask & mask.fmt) | (frame_ext == cell_ext);
        hit    = cell_en & dir_ok & fmt_ok & (diff == '0);
    end
endmodule

// File: rtl/rxf_first_pick.sv
module rxf_first_pick #(
    parameter int NUM_MB = 32,
    localparam int IDX_W = $clog2(NUM_MB)
)(
    input  logic [NUM_MB-1:0] match,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        // descending scan so the lowest matching index is left standing
        for (int i = NUM_MB - 2; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        if (!any && match[NUM_MB-1]) begin
            any = 1'b1;
            idx = IDX_W'(NUM_MB - 1);
        end
    end
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
    import rxf_pkg::*;
#(
    parameter int NUM_MB = 32,
    localparam int IDX_W = $clog2(NUM_MB)
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_valid,
    input  logic [ID_W-1:0]        frame_id,
    input  logic                   frame_ext,
    input  logic                   frame_rtr,
    input  logic [NUM_MB*ID_W-1:0] mb_id,
    input  logic [NUM_MB-1:0]      mb_ext,
    input  logic [NUM_MB-1:0]      mb_rx,
    input  logic [NUM_MB-1:0]      mb_en,
    input  logic [NUM_MB-1:0]      mb_use_mask,
    input  logic                   gmask_we,
    input  logic                   lmask_we,
    input  logic [ID_W-1:0]        mask_wr_id,
    input  logic                   mask_wr_fmt,
    input  logic [NUM_MB-1:0]      pend_clr,
    input  logic [NUM_MB-1:0]      lost_clr,
    output logic                   hit_valid,
    output logic [IDX_W-1:0]       hit_idx,
    output logic [NUM_MB-1:0]      rx_pend,
    output logic [NUM_MB-1:0]      rx_lost
);
    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [NUM_MB-1:0] pend;
        logic [NUM_MB-1:0] lost;
    } flt_state_t;

    flt_state_t st_d, st_q;

    acc_mask_t         g_mask, l_mask, wr_mask;
    logic [NUM_MB-1:0] match;
    logic              win_any;
    logic [IDX_W-1:0]  win_idx;

    assign wr_mask = '{id: mask_wr_id, fmt: mask_wr_fmt};

    rxf_mask_bank u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .g_we    (gmask_we),
        .l_we    (lmask_we),
        .wr_mask (wr_mask),
        .g_mask  (g_mask),
        .l_mask  (l_mask)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MB; gi++) begin : g_cell
            localparam bit IS_LAST = (gi == NUM_MB - 1);
            rxf_match_cell #(.FALLBACK(IS_LAST)) u_cell (
                .frame_id      (frame_id),
                .frame_ext     (frame_ext),
                .frame_rtr     (frame_rtr),
                .cell_id       (mb_id[gi*ID_W +: ID_W]),
                .cell_ext      (mb_ext[gi]),
                .cell_rx       (mb_rx[gi]),
                .cell_en       (mb_en[gi]),
                .cell_use_mask (mb_use_mask[gi]),
                .mask          (IS_LAST ? l_mask : g_mask),
                .hit           (match[gi])
            );
        end
    endgenerate

    rxf_first_pick #(.NUM_MB(NUM_MB)) u_pick (
        .match (match),
        .any   (win_any),
        .idx   (win_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hit  = 1'b0;
        st_d.pend = st_q.pend & ~pend_clr;
        st_d.lost = st_q.lost & ~lost_clr;
        if (frame_valid && win_any) begin
            st_d.hit           = 1'b1;
            st_d.idx           = win_idx;
            st_d.pend[win_idx] = 1'b1;
            // a clear in the same cycle counts as served first
            if (st_q.pend[win_idx] && !pend_clr[win_idx])
                st_d.lost[win_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_valid = st_q.hit;
    assign hit_idx   = st_q.idx;
    assign rx_pend   = st_q.pend;
    assign rx_lost   = st_q.lost;

    assert_hit_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(frame_valid));
    assert_hit_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> rx_pend[hit_idx]);
    assert_hit_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (($past(mb_en) & (NUM_MB'(1) << hit_idx)) != '0));
    assert_data_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !$past(frame_rtr) && hit_idx != IDX_W'(NUM_MB - 1))
        |-> (($past(mb_rx) & (NUM_MB'(1) << hit_idx)) != '0));

    generate
        for (gi = 0; gi < NUM_MB; gi++) begin : g_flag_chk
            assert_pend_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rx_pend[gi]) |-> (hit_valid && hit_idx == IDX_W'(gi)));
            assert_lost_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rx_lost[gi]) |-> $past(rx_pend[gi]));
        end
    endgenerate
endmodule

// File: tb/rx_accept_filter_bench.sv
module rx_accept_filter_bench;
    localparam int NUM_MB = 32;
    localparam int IW     = 29;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   frame_valid = 1'b0;
    logic [IW-1:0]          frame_id = '0;
    logic                   frame_ext = 1'b0;
    logic                   frame_rtr = 1'b0;
    logic [NUM_MB*IW-1:0]   mb_id = '0;
    logic [NUM_MB-1:0]      mb_ext = '0, mb_rx = '0, mb_en = '0, mb_use_mask = '0;
    logic                   gmask_we = 1'b0, lmask_we = 1'b0;
    logic [IW-1:0]          mask_wr_id = '0;
    logic                   mask_wr_fmt = 1'b0;
    logic [NUM_MB-1:0]      pend_clr = '0, lost_clr = '0;
    logic                   hit_valid;
    logic [4:0]             hit_idx;
    logic [NUM_MB-1:0]      rx_pend, rx_lost;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rx_accept_filter u_rx_accept_filter (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_id(frame_id),
        .frame_ext(frame_ext), .frame_rtr(frame_rtr), .mb_id(mb_id), .mb_ext(mb_ext),
        .mb_rx(mb_rx), .mb_en(mb_en), .mb_use_mask(mb_use_mask), .gmask_we(gmask_we),
        .lmask_we(lmask_we), .mask_wr_id(mask_wr_id), .mask_wr_fmt(mask_wr_fmt),
        .pend_clr(pend_clr), .lost_clr(lost_clr), .hit_valid(hit_valid),
        .hit_idx(hit_idx), .rx_pend(rx_pend), .rx_lost(rx_lost)
    );

    typedef struct packed {
        logic [IW-1:0] id;
        logic          ext;
        logic          rtr;
        logic          val;
        logic [4:0]    idx;
    } vec_t;

    localparam vec_t VEC [0:13] = '{
        '{{11'h123, 18'h00000}, 1'b0, 1'b0, 1'b1, 5'd2 },  // R1 R4
        '{{11'h123, 18'h3FFFF}, 1'b0, 1'b0, 1'b1, 5'd2 },  // R1 low bits ignored
        '{{11'h123, 18'h00000}, 1'b1, 1'b0, 1'b0, 5'd0 },  // R6 format differs
        '{29'h1ABCDE0,          1'b1, 1'b0, 1'b1, 5'd5 },  // R2
        '{29'h1ABCDE1,          1'b1, 1'b0, 1'b0, 5'd0 },  // R2 bit 0 counts
        '{{11'h30A, 18'h00000}, 1'b0, 1'b0, 1'b1, 5'd9 },  // R3 masked bits
        '{{11'h310, 18'h00000}, 1'b0, 1'b0, 1'b0, 5'd0 },  // R3 unmasked bit
        '{29'h0AAAAAA,          1'b1, 1'b0, 1'b0, 5'd0 },  // R8 data vs transmit box
        '{29'h0AAAAAA,          1'b1, 1'b1, 1'b1, 5'd12},  // R8 remote ignores direction
        '{{11'h555, 18'h00000}, 1'b0, 1'b0, 1'b0, 5'd0 },  // R7 disabled
        '{{11'h7A5, 18'h00000}, 1'b0, 1'b0, 1'b1, 5'd31},  // R5 fallback
        '{{11'h7A5, 18'h00000}, 1'b1, 1'b0, 1'b1, 5'd31},  // R6 local fmt mask
        '{{11'h6A5, 18'h00000}, 1'b0, 1'b0, 1'b0, 5'd0 },  // R5 local mask limits
        '{{11'h7C0, 18'h00000}, 1'b0, 1'b0, 1'b1, 5'd20}   // R5 lower box beats 31
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one frame cycle with optional same-cycle side inputs; samples after the edge
    task automatic cycle(input logic fv, input logic [IW-1:0] id, input logic ext,
                         input logic rtr, input logic [NUM_MB-1:0] pc,
                         input logic [NUM_MB-1:0] lc, input logic gwe,
                         input logic [IW-1:0] mid, input logic mfmt);
        @(negedge clk);
        frame_valid = fv; frame_id = id; frame_ext = ext; frame_rtr = rtr;
        pend_clr = pc; lost_clr = lc;
        gmask_we = gwe; mask_wr_id = mid; mask_wr_fmt = mfmt;
        @(negedge clk);
        frame_valid = 1'b0; pend_clr = '0; lost_clr = '0; gmask_we = 1'b0;
    endtask

    task automatic set_mb(input int n, input logic [IW-1:0] id, input logic ext,
                          input logic rx, input logic en, input logic um);
        mb_id[n*IW +: IW] = id;
        mb_ext[n] = ext; mb_rx[n] = rx; mb_en[n] = en; mb_use_mask[n] = um;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        set_mb(2,  {11'h123, 18'h0}, 1'b0, 1'b1, 1'b1, 1'b0);
        set_mb(5,  29'h1ABCDE0,      1'b1, 1'b1, 1'b1, 1'b0);
        set_mb(7,  {11'h123, 18'h0}, 1'b0, 1'b1, 1'b1, 1'b0);
        set_mb(9,  {11'h300, 18'h0}, 1'b0, 1'b1, 1'b1, 1'b1);
        set_mb(12, 29'h0AAAAAA,      1'b1, 1'b0, 1'b1, 1'b0);
        set_mb(14, {11'h555, 18'h0}, 1'b0, 1'b1, 1'b0, 1'b0);
        set_mb(20, {11'h7C0, 18'h0}, 1'b0, 1'b1, 1'b1, 1'b0);
        set_mb(31, {11'h700, 18'h0}, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("reset hit_valid R9", 64'(hit_valid), 64'd0);
        chk("reset rx_pend R10", 64'(rx_pend), 64'd0);
        chk("reset rx_lost R11", 64'(rx_lost), 64'd0);
        rst_n = 1'b1;

        // global mask: std low 4 bits don't-care, format checked
        cycle(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, {11'h00F, 18'h0}, 1'b0);
        // local mask: std low 8 bits don't-care, format ignored
        @(negedge clk);
        lmask_we = 1'b1; mask_wr_id = {11'h0FF, 18'h0}; mask_wr_fmt = 1'b1;
        @(negedge clk);
        lmask_we = 1'b0;

        for (int v = 0; v < 14; v++) begin
            cycle(1'b1, VEC[v].id, VEC[v].ext, VEC[v].rtr, '0, '0, 1'b0, '0, 1'b0);
            chk($sformatf("vec%0d hit_valid R9", v), 64'(hit_valid), 64'(VEC[v].val));
            if (VEC[v].val)
                chk($sformatf("vec%0d hit_idx R4", v), 64'(hit_idx), 64'(VEC[v].idx));
            chk($sformatf("vec%0d rx_pend R10", v), 64'(rx_pend),
                VEC[v].val ? (64'd1 << VEC[v].idx) : 64'd0);
            cycle(1'b0, '0, 1'b0, 1'b0, '1, '1, 1'b0, '0, 1'b0);
        end

        // R9: pulse lasts one cycle
        cycle(1'b1, {11'h123, 18'h0}, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
        chk("pulse high R9", 64'(hit_valid), 64'd1);
        @(negedge clk);
        chk("pulse low R9", 64'(hit_valid), 64'd0);
        chk("single store no lost R11", 64'(rx_lost), 64'd0);

        // R12: store and pending clear in the same cycle
        cycle(1'b1, {11'h123, 18'h0}, 1'b0, 1'b0, 32'h4, '0, 1'b0, '0, 1'b0);
        chk("store beats clear pend R12", 64'(rx_pend), 64'h4);
        chk("clear suppresses lost R12", 64'(rx_lost), 64'd0);

        // R11: overwrite while pending
        cycle(1'b1, {11'h123, 18'h0}, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
        chk("overwrite sets lost R11", 64'(rx_lost), 64'h4);
        chk("overwrite keeps pend R10", 64'(rx_pend), 64'h4);

        // R12: lost event and lost clear in the same cycle
        cycle(1'b1, {11'h123, 18'h0}, 1'b0, 1'b0, '0, 32'h4, 1'b0, '0, 1'b0);
        chk("lost set beats clear R12", 64'(rx_lost), 64'h4);
        cycle(1'b0, '0, 1'b0, 1'b0, 32'h4, 32'h4, 1'b0, '0, 1'b0);
        chk("clear pend R12", 64'(rx_pend), 64'd0);
        chk("clear lost R12", 64'(rx_lost), 64'd0);

        // R13: mask write in the frame's cycle is not yet seen
        cycle(1'b1, {11'h310, 18'h0}, 1'b0, 1'b0, '0, '0, 1'b1, {11'h01F, 18'h0}, 1'b0);
        chk("old mask used R13", 64'(hit_valid), 64'd0);
        chk("no match no flags R9", 64'(rx_pend), 64'd0);
        cycle(1'b1, {11'h310, 18'h0}, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
        chk("new mask hit R13", 64'(hit_valid), 64'd1);
        chk("new mask idx R13", 64'(hit_idx), 64'd9);

        // R3: same frame, mask-select off on mailbox 9 -> exact match needed
        mb_use_mask[9] = 1'b0;
        cycle(1'b1, {11'h30A, 18'h0}, 1'b0, 1'b0, '1, '1, 1'b0, '0, 1'b0);
        chk("mask select off R3", 64'(hit_valid), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule